// File: doc/BRIEF.md
# Supervisor Control Register Bank

This block holds the handful of control registers that a simple processor core needs for privileged operation. There is a status word, a saved exception PC, a captured faulting address, an exception vector base, a read-only memory-size register in pages, and a pair of host mailbox ports. Software reaches them through move-from and move-to operations that name a register by a 5-bit number. The read path is combinational. A write takes effect at the next clock edge.

The block also works out the operand width the core runs at. The width is 64 bits or 32 bits, and it is chosen per privilege level from the status bits. In 32-bit mode, every value written and every value read is sign-extended from bit 31. When the core signals a trap, the block updates the status word and captures the trapping PC and faulting address. A trap that arrives while exceptions are already disabled sets a sticky error-mode flag instead.

Top module: `sup_ctrl_regs`

## Requirements
- R1: After reset, status reads 0x11 (supervisor and kernel-64 set) when 64-bit support is enabled, and 0x01 when it is disabled. Exception PC, faulting address and vector base read zero. `err_mode` and `tohost_valid` are low.
- R2: Register numbers are decoded as follows:
  - 0: status
  - 1: exception PC
  - 2: faulting address (read only)
  - 3: vector base
  - 8: memory pages (read only)
  - 16: host outbound (write only)
  - 17: host inbound (read only), which returns `fromhost_data`
- R3: A read of number 8 returns the `MEM_BYTES` parameter shifted right by 12.
- R4: A read of any number outside {0,1,2,3,8,17} returns all ones. A write to a number outside {0,1,3,16} changes nothing.
- R5: A write to the vector base stores the value with bits 11:0 cleared.
- R6: `wide_mode` is high when status bit 0 (supervisor) and bit 4 (kernel-64) are both set, or when bit 0 is clear and bit 3 (user-64) is set. Otherwise it is low.
- R7: While `wide_mode` is low, write data is sign-extended from bit 31 before it is stored, and read data is sign-extended from bit 31 before it is returned.
- R8: A status write keeps only bits 7:0. When the `HAS_WIDE` parameter is 0, the write also clears bits 3 and 4.
- R9: When `trap_valid` is high and status bit 1 (exceptions enabled) is set, the next state is as follows:
  - bit 1 is cleared and bit 0 is set;
  - bit 2 (previous supervisor) takes the old bit 0;
  - the exception PC takes `trap_pc` and the faulting address takes `trap_badva`.
- R10: When `trap_valid` is high and status bit 1 is clear, `err_mode` rises and stays high until reset, and no register changes.
- R11: While status bit 0 is clear, `priv_fault` is high whenever `rd_en` or `wr_en` is high, and writes have no effect.
- R12: A write to number 16 raises `tohost_valid` for exactly one cycle after the write edge, with `tohost_data` holding the (width-adjusted) value. A write in a trap cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request |
| rd_num | input | 5 | Register number to read |
| rd_data | output | XLEN | Read value (combinational) |
| wr_en | input | 1 | Write request |
| wr_num | input | 5 | Register number to write |
| wr_data | input | XLEN | Write value |
| trap_valid | input | 1 | Trap entry strobe |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_badva | input | XLEN | Faulting address for the trap |
| fromhost_data | input | XLEN | Host inbound mailbox value |
| tohost_valid | output | 1 | One-cycle pulse on an outbound write |
| tohost_data | output | XLEN | Outbound mailbox value |
| wide_mode | output | 1 | Current operand width is 64 bits |
| priv_fault | output | 1 | Access attempted outside supervisor mode |
| err_mode | output | 1 | Sticky: trap taken with exceptions disabled |

## Verification
The bench walks the whole privilege cycle. It moves from supervisor to narrow supervisor, then to wide user mode, traps back and traps again. This exposes a width rule that ignores the privilege level, because that would report the wrong `wide_mode` after each status change. It also catches a missing sign extension: a narrow write of 0xFFFF8000, or the read of a captured 0x80001000 address, would come back zero-padded. Trap entry is checked from both supervisor and user mode, so a previous-supervisor bit wired to a constant shows up as a wrong status value. The bench also covers writes to read-only numbers, the bits of an outbound write attempted in user mode, and a second trap with exceptions off. Each of these would visibly change a register or pulse `tohost_valid` if the block failed to discard it. A second instance with 64-bit support disabled shows whether the width bits are scrubbed.

// File: rtl/sup_ctrl_pkg.sv
package sup_ctrl_pkg;

    // status word, bit 0 first: s=0, et=1, ps=2, ux=3, kx=4, spare=7:5
    typedef struct packed {
        logic [2:0] spare;
        logic       kx;
        logic       ux;
        logic       ps;
        logic       et;
        logic       s;
    } stat_t;

    localparam int STAT_W  = $bits(stat_t);
    localparam int NUM_W   = 5;

    typedef enum logic [NUM_W-1:0] {
        NUM_STATUS   = 5'd0,
        NUM_EPC      = 5'd1,
        NUM_BADVA    = 5'd2,
        NUM_EBASE    = 5'd3,
        NUM_MEMPG    = 5'd8,
        NUM_TOHOST   = 5'd16,
        NUM_FROMHOST = 5'd17
    } regnum_e;

    // strip width bits when the core has no 64-bit support
    function automatic stat_t scrub(input stat_t v, input logic wide_ok);
        stat_t r;
        r = v;
        if (!wide_ok) begin
            r.kx = 1'b0;
            r.ux = 1'b0;
        end
        return r;
    endfunction

    // status after a normal trap entry
    function automatic stat_t enter_trap(input stat_t old);
        stat_t r;
        r    = old;
        r.et = 1'b0;
        r.ps = old.s;
        r.s  = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/sup_ctrl_width.sv
module sup_ctrl_width #(
    parameter int XLEN = 64,
    parameter int HALF = 32
) (
    input  logic            s_bit,
    input  logic            kx_bit,
    input  logic            ux_bit,
    input  logic [XLEN-1:0] wr_raw,
    input  logic [XLEN-1:0] rd_raw,
    output logic            wide,
    output logic [XLEN-1:0] wr_val,
    output logic [XLEN-1:0] rd_val
);
    localparam int EXT = XLEN - HALF;

    assign wide = s_bit ? kx_bit : ux_bit;

    generate
        if (EXT > 0) begin : g_ext
            assign wr_val = wide ? wr_raw : {{EXT{wr_raw[HALF-1]}}, wr_raw[HALF-1:0]};
            assign rd_val = wide ? rd_raw : {{EXT{rd_raw[HALF-1]}}, rd_raw[HALF-1:0]};
        end else begin : g_flat
            assign wr_val = wr_raw;
            assign rd_val = rd_raw;
        end
    endgenerate
endmodule

// File: rtl/sup_ctrl_status.sv
module sup_ctrl_status
    import sup_ctrl_pkg::*;
#(
    parameter bit HAS_WIDE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stat,
    input  logic [STAT_W-1:0] wr_bits,
    input  logic              trap_take,
    input  logic              trap_err,
    output stat_t             stat_q,
    output logic              err_q
);
    localparam stat_t RESET_STAT = stat_t'({3'b000, HAS_WIDE, 4'b0001});

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= RESET_STAT;
            err_q  <= 1'b0;
        end else begin
            if (trap_take)
                stat_q <= scrub(enter_trap(stat_q), HAS_WIDE);
            else if (wr_stat)
                stat_q <= scrub(stat_t'(wr_bits), HAS_WIDE);
            if (trap_err)
                err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/sup_ctrl_store.sv
module sup_ctrl_store
    import sup_ctrl_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int PAGE_SHIFT = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_go,
    input  logic [NUM_W-1:0] wr_num,
    input  logic [XLEN-1:0]  wr_val,
    input  logic             trap_take,
    input  logic [XLEN-1:0]  trap_pc,
    input  logic [XLEN-1:0]  trap_badva,
    output logic [XLEN-1:0]  epc_q,
    output logic [XLEN-1:0]  badva_q,
    output logic [XLEN-1:0]  ebase_q,
    output logic             tohost_valid,
    output logic [XLEN-1:0]  tohost_data
);
    localparam logic [XLEN-1:0] BASE_KEEP = ~((XLEN'(1) << PAGE_SHIFT) - XLEN'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q        <= '0;
            badva_q      <= '0;
            ebase_q      <= '0;
            tohost_valid <= 1'b0;
            tohost_data  <= '0;
        end else begin
            tohost_valid <= 1'b0;
            if (trap_take) begin
                epc_q   <= trap_pc;
                badva_q <= trap_badva;
            end else if (wr_go) begin
                case (regnum_e'(wr_num))
                    NUM_EPC:    epc_q <= wr_val;
                    NUM_EBASE:  ebase_q <= wr_val & BASE_KEEP;
                    NUM_TOHOST: begin
                        tohost_valid <= 1'b1;
                        tohost_data  <= wr_val;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sup_ctrl_regs.sv
module sup_ctrl_regs
    import sup_ctrl_pkg::*;
#(
    parameter int              XLEN       = 64,
    parameter int              HALF       = 32,
    parameter int              PAGE_SHIFT = 12,
    parameter bit              HAS_WIDE   = 1'b1,
    parameter logic [XLEN-1:0] MEM_BYTES  = XLEN'(32'h1000_0000)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_en,
    input  logic [4:0]      rd_num,
    output logic [XLEN-1:0] rd_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_num,
    input  logic [XLEN-1:0] wr_data,
    input  logic            trap_valid,
    input  logic [XLEN-1:0] trap_pc,
    input  logic [XLEN-1:0] trap_badva,
    input  logic [XLEN-1:0] fromhost_data,
    output logic            tohost_valid,
    output logic [XLEN-1:0] tohost_data,
    output logic            wide_mode,
    output logic            priv_fault,
    output logic            err_mode
);
    localparam logic [XLEN-1:0] MEM_PAGES = MEM_BYTES >> PAGE_SHIFT;

    stat_t            stat_q;
    logic             err_q;
    logic [XLEN-1:0]  epc_q, badva_q, ebase_q;
    logic [XLEN-1:0]  wr_val, rd_raw, rd_val;
    logic             wide;
    logic             trap_take, trap_err, wr_go, wr_stat;

    assign trap_take = trap_valid &  stat_q.et;
    assign trap_err  = trap_valid & ~stat_q.et;
    assign wr_go     = wr_en & stat_q.s & ~trap_valid;
    assign wr_stat   = wr_go & (regnum_e'(wr_num) == NUM_STATUS);

    sup_ctrl_width #(.XLEN(XLEN), .HALF(HALF)) u_width (
        .s_bit  (stat_q.s),
        .kx_bit (stat_q.kx),
        .ux_bit (stat_q.ux),
        .wr_raw (wr_data),
        .rd_raw (rd_raw),
        .wide   (wide),
        .wr_val (wr_val),
        .rd_val (rd_val)
    );

    sup_ctrl_status #(.HAS_WIDE(HAS_WIDE)) u_status (
        .clk       (clk),
        .rst       (rst),
        .wr_stat   (wr_stat),
        .wr_bits   (wr_val[STAT_W-1:0]),
        .trap_take (trap_take),
        .trap_err  (trap_err),
        .stat_q    (stat_q),
        .err_q     (err_q)
    );

    sup_ctrl_store #(.XLEN(XLEN), .PAGE_SHIFT(PAGE_SHIFT)) u_store (
        .clk          (clk),
        .rst          (rst),
        .wr_go        (wr_go),
        .wr_num       (wr_num),
        .wr_val       (wr_val),
        .trap_take    (trap_take),
        .trap_pc      (trap_pc),
        .trap_badva   (trap_badva),
        .epc_q        (epc_q),
        .badva_q      (badva_q),
        .ebase_q      (ebase_q),
        .tohost_valid (tohost_valid),
        .tohost_data  (tohost_data)
    );

    always_comb begin
        case (regnum_e'(rd_num))
            NUM_STATUS:   rd_raw = XLEN'(stat_q);
            NUM_EPC:      rd_raw = epc_q;
            NUM_BADVA:    rd_raw = badva_q;
            NUM_EBASE:    rd_raw = ebase_q;
            NUM_MEMPG:    rd_raw = MEM_PAGES;
            NUM_FROMHOST: rd_raw = fromhost_data;
            default:      rd_raw = '1;
        endcase
    end

    assign rd_data    = rd_val;
    assign wide_mode  = wide;
    assign priv_fault = (rd_en | wr_en) & ~stat_q.s;
    assign err_mode   = err_q;
endmodule

// File: rtl/sup_ctrl_regs_chk.sv
module sup_ctrl_regs_chk
    import sup_ctrl_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int HALF = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            rd_en,
    input logic [4:0]      rd_num,
    input logic [XLEN-1:0] rd_data,
    input logic            wr_en,
    input logic            trap_valid,
    input logic [XLEN-1:0] trap_pc,
    input logic            tohost_valid,
    input logic            wide_mode,
    input logic            err_mode,
    input stat_t           stat_q,
    input logic [XLEN-1:0] epc_q
);
    logic unmapped;
    assign unmapped = !(rd_num inside {5'd0, 5'd1, 5'd2, 5'd3, 5'd8, 5'd17});

    // R4: unmapped reads give all ones
    assert_unmapped_ones_R4: assert property (@(posedge clk) disable iff (rst)
        rd_en && stat_q.s && unmapped |-> rd_data == '1);

    // R7: narrow reads are sign-extended
    assert_narrow_sext_R7: assert property (@(posedge clk) disable iff (rst)
        !wide_mode |-> rd_data[XLEN-1:HALF] == {(XLEN-HALF){rd_data[HALF-1]}});

    // R8: reserved status bits stay zero
    assert_status_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
        rd_en && stat_q.s && rd_num == 5'd0 |-> rd_data[XLEN-1:8] == '0);

    // R9: trap entry with exceptions enabled
    assert_trap_entry_R9: assert property (@(posedge clk) disable iff (rst)
        trap_valid && stat_q.et |=> stat_q.s && !stat_q.et && epc_q == $past(trap_pc));

    // R10: error mode is sticky
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        err_mode |=> err_mode);

    // R10: a trap with exceptions off leaves EPC alone
    assert_err_no_update_R10: assert property (@(posedge clk) disable iff (rst)
        trap_valid && !stat_q.et |=> $stable(epc_q) && err_mode);

    // R11: user-mode writes change nothing
    assert_user_write_inert_R11: assert property (@(posedge clk) disable iff (rst)
        wr_en && !stat_q.s && !trap_valid |=> $stable(epc_q) && !tohost_valid);
endmodule

bind sup_ctrl_regs sup_ctrl_regs_chk #(.XLEN(XLEN), .HALF(HALF)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_en        (rd_en),
    .rd_num       (rd_num),
    .rd_data      (rd_data),
    .wr_en        (wr_en),
    .trap_valid   (trap_valid),
    .trap_pc      (trap_pc),
    .tohost_valid (tohost_valid),
    .wide_mode    (wide_mode),
    .err_mode     (err_mode),
    .stat_q       (stat_q),
    .epc_q        (epc_q)
);

// File: tb/sup_ctrl_regs_bench.sv
module sup_ctrl_regs_bench;
    localparam int XLEN = 64;
    localparam logic [63:0] MEMB = 64'h1000_0000;
    localparam logic [63:0] HOSTV = 64'h0000_0000_0000_CAFE;
    localparam int NVEC = 12;
    // {is_write, num, data, expected}
    localparam logic [133:0] VEC [NVEC] = '{
        {1'b1, 5'd1,  64'h1234_5678_9ABC_DEF0, 64'h0},
        {1'b0, 5'd1,  64'h0, 64'h1234_5678_9ABC_DEF0},
        {1'b1, 5'd3,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        {1'b0, 5'd3,  64'h0, 64'hFFFF_FFFF_FFFF_F000},
        {1'b0, 5'd8,  64'h0, 64'h0000_0000_0001_0000},
        {1'b0, 5'd5,  64'h0, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b0, 5'd16, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b1, 5'd2,  64'h55, 64'h0},
        {1'b0, 5'd2,  64'h0, 64'h0},
        {1'b1, 5'd17, 64'h77, 64'h0},
        {1'b0, 5'd17, 64'h0, HOSTV},
        {1'b0, 5'd1,  64'h0, 64'h1234_5678_9ABC_DEF0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        rd_en = 0, wr_en = 0, trap_valid = 0;
    logic [4:0]  rd_num = 0, wr_num = 0;
    logic [63:0] wr_data = 0, trap_pc = 0, trap_badva = 0;
    logic [63:0] rd_data, tohost_data;
    logic        tohost_valid, wide_mode, priv_fault, err_mode;

    logic        n_rd_en = 0, n_wr_en = 0;
    logic [4:0]  n_rd_num = 0, n_wr_num = 0;
    logic [63:0] n_wr_data = 0, n_rd_data, n_tohost_data;
    logic        n_tohost_valid, n_wide, n_fault, n_err;

    int total = 0;
    int failed = 0;

    sup_ctrl_regs #(.MEM_BYTES(MEMB)) u_sup_ctrl_regs (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_num(rd_num), .rd_data(rd_data),
        .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
        .trap_valid(trap_valid), .trap_pc(trap_pc), .trap_badva(trap_badva),
        .fromhost_data(HOSTV), .tohost_valid(tohost_valid), .tohost_data(tohost_data),
        .wide_mode(wide_mode), .priv_fault(priv_fault), .err_mode(err_mode));

    sup_ctrl_regs #(.MEM_BYTES(MEMB), .HAS_WIDE(1'b0)) u_sup_ctrl_regs_narrow (
        .clk(clk), .rst(rst), .rd_en(n_rd_en), .rd_num(n_rd_num), .rd_data(n_rd_data),
        .wr_en(n_wr_en), .wr_num(n_wr_num), .wr_data(n_wr_data),
        .trap_valid(1'b0), .trap_pc(64'h0), .trap_badva(64'h0),
        .fromhost_data(HOSTV), .tohost_valid(n_tohost_valid), .tohost_data(n_tohost_data),
        .wide_mode(n_wide), .priv_fault(n_fault), .err_mode(n_err));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] num, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1; wr_num = num; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] num, input logic [63:0] exp);
        @(negedge clk);
        rd_en = 1; rd_num = num;
        #1;
        check(req, rd_data, exp);
        rd_en = 0;
    endtask

    task automatic trap(input logic [63:0] pc, input logic [63:0] va);
        @(negedge clk);
        trap_valid = 1; trap_pc = pc; trap_badva = va;
        @(negedge clk);
        trap_valid = 0;
    endtask

    task automatic n_wr(input logic [4:0] num, input logic [63:0] d);
        @(negedge clk);
        n_wr_en = 1; n_wr_num = num; n_wr_data = d;
        @(negedge clk);
        n_wr_en = 0;
    endtask

    task automatic n_rd_chk(input string req, input logic [4:0] num, input logic [63:0] exp);
        @(negedge clk);
        n_rd_en = 1; n_rd_num = num;
        #1;
        check(req, n_rd_data, exp);
        n_rd_en = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    initial begin
        #50000;
        failed++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd_chk("R1 status", 5'd0, 64'h11);
        rd_chk("R1 epc", 5'd1, 64'h0);
        rd_chk("R1 badva", 5'd2, 64'h0);
        rd_chk("R1 ebase", 5'd3, 64'h0);
        check("R1 err_mode", {63'h0, err_mode}, 64'h0);
        check("R1 tohost_valid", {63'h0, tohost_valid}, 64'h0);
        n_rd_chk("R1 narrow status", 5'd0, 64'h01);

        // R2 R3 R4 R5 vector walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][133])
                wr(VEC[i][132:128], VEC[i][127:64]);
            else
                rd_chk($sformatf("R2/R3/R4/R5 vec%0d", i), VEC[i][132:128], VEC[i][63:0]);
        end

        // R12 outbound pulse
        @(negedge clk);
        wr_en = 1; wr_num = 5'd16; wr_data = 64'hDEAD_BEEF_0000_0001;
        @(negedge clk);
        wr_en = 0;
        check("R12 valid", {63'h0, tohost_valid}, 64'h1);
        check("R12 data", tohost_data, 64'hDEAD_BEEF_0000_0001);
        @(negedge clk);
        check("R12 one cycle", {63'h0, tohost_valid}, 64'h0);

        // R8 reserved bits dropped
        wr(5'd0, 64'hFFFF_FFFF_FFFF_FFF3);
        rd_chk("R8 mask", 5'd0, 64'hF3);

        // R9 trap from supervisor
        wr(5'd0, 64'h13);
        trap(64'h2000, 64'h1234);
        rd_chk("R9 status from S", 5'd0, 64'h15);
        rd_chk("R9 epc", 5'd1, 64'h2000);
        rd_chk("R9 badva", 5'd2, 64'h1234);

        // R6 narrow supervisor, R7 write sign extension
        wr(5'd0, 64'h03);
        check("R6 narrow S", {63'h0, wide_mode}, 64'h0);
        wr(5'd1, 64'h0000_0000_FFFF_8000);
        rd_chk("R7 write sext", 5'd1, 64'hFFFF_FFFF_FFFF_8000);

        // R6 wide user, R11 faults
        wr(5'd0, 64'h0A);
        check("R6 wide user", {63'h0, wide_mode}, 64'h1);
        @(negedge clk);
        rd_en = 1; rd_num = 5'd1;
        #1;
        check("R11 read fault", {63'h0, priv_fault}, 64'h1);
        rd_en = 0;
        @(negedge clk);
        wr_en = 1; wr_num = 5'd16; wr_data = 64'h55;
        #1;
        check("R11 write fault", {63'h0, priv_fault}, 64'h1);
        @(negedge clk);
        wr_en = 0;
        check("R11 no outbound", {63'h0, tohost_valid}, 64'h0);
        wr(5'd0, 64'h13);
        check("R11 status kept", {63'h0, wide_mode}, 64'h1);
        @(negedge clk);
        rd_en = 1; rd_num = 5'd0;
        #1;
        check("R11 still user", {63'h0, priv_fault}, 64'h1);
        rd_en = 0;

        // R9 trap from user; R7 read sign extension
        trap(64'h4000, 64'h0000_0000_8000_1000);
        rd_chk("R9 status from U", 5'd0, 64'h09);
        rd_chk("R9 epc user", 5'd1, 64'h4000);
        rd_chk("R7 read sext", 5'd2, 64'hFFFF_FFFF_8000_1000);
        check("R6 narrow after trap", {63'h0, wide_mode}, 64'h0);

        // R10 trap with exceptions off
        check("R10 err before", {63'h0, err_mode}, 64'h0);
        trap(64'h8888, 64'h9999);
        check("R10 err set", {63'h0, err_mode}, 64'h1);
        rd_chk("R10 epc kept", 5'd1, 64'h4000);
        rd_chk("R10 status kept", 5'd0, 64'h09);
        repeat (3) @(negedge clk);
        check("R10 sticky", {63'h0, err_mode}, 64'h1);

        // R8 R6 R7 without 64-bit support
        n_wr(5'd0, 64'h1B);
        n_rd_chk("R8 width bits cleared", 5'd0, 64'h03);
        check("R6 no wide", {63'h0, n_wide}, 64'h0);
        n_wr(5'd1, 64'hAAAA_AAAA_1234_5678);
        n_rd_chk("R7 upper dropped", 5'd1, 64'h1234_5678);
        n_wr(5'd1, 64'h0000_0000_8000_0000);
        n_rd_chk("R7 negative", 5'd1, 64'hFFFF_FFFF_8000_0000);

        finish_run();
    end
endmodule